// File: doc/BRIEF.md
# Counted Fixed-Point Multiply-Accumulate Unit

This block sums the products of two streams of signed two's-complement fixed-point samples. On every rising clock edge after reset is released it takes one sample from each input, forms their product at full precision and adds that product to a running sum. A 10-bit run-time count selects how many products make up one result. When that many products have been summed, a ready flag goes high. The result and the flag then stay frozen until the next reset.

The x operand has `X_W` bits and the y operand has `Y_W` bits. Each may carry its own number of fraction bits. Fraction bits need no logic: the binary point of the result sits at the sum of the two operand fraction lengths. The product is kept at `X_W+Y_W` bits. The accumulator adds `CNT_W` guard bits on top of that. This lets it absorb up to 2^`CNT_W`-1 worst-case products without wrapping, so no quantization or overflow can occur.

Top module: `fxp_mac_count`

## Requirements
- R1: While `rst_ni` is low, `mac_o` is 0 and `ready_o` is 0. Both are forced at once by an asynchronous reset, without waiting for a clock edge.
- R2: The product of `x_i` and `y_i` is formed as a signed `X_W+Y_W`-bit value with no truncation. It is sign-extended before it is added, so negative products subtract from the sum.
- R3: `mac_o` is `X_W+Y_W+CNT_W` bits wide and signed. A sum of 1023 products of the most negative operands, or of the most negative with the most positive, is exact.
- R4: After k rising edges since reset release, with k < N, `mac_o` equals the sum of the first k products. Exactly one (x, y) pair is consumed per edge.
- R5: `ready_o` stays low until the edge that adds the N-th product, and it is high right after that edge.
- R6: Once `ready_o` is high, `mac_o` and `ready_o` do not change, whatever `x_i` and `y_i` do, until reset.
- R7: With `n_i` = 0, `ready_o` goes high after the first edge following reset release, and `mac_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | X_W | First signed operand sample |
| y_i | input | Y_W | Second signed operand sample |
| n_i | input | CNT_W | Number of products to sum (unsigned) |
| mac_o | output | X_W+Y_W+CNT_W | Signed running or final sum |
| ready_o | output | 1 | High once N products have been summed |

## Verification
The hardest condition to reach is the accumulator's headroom limit. It is only touched when the longest run, 1023 products, is fed extreme operands on every cycle. Random data stays far from the limit.

The stimulus therefore runs two full-length passes: one with the most negative value on both inputs, and one with most negative times most positive. Each pass drives the sum to within a factor of two of the signed range. Short runs and the N = 0 case check the ready timing and the freeze at its edges.

// File: rtl/fxp_mac_pkg.sv
package fxp_mac_pkg;
  // accumulator width: full product plus one guard bit per count bit
  function automatic int acc_width(input int x_w, input int y_w, input int cnt_w);
    return x_w + y_w + cnt_w;
  endfunction
endpackage

// File: rtl/fxp_mul.sv
module fxp_mul #(
  parameter int X_W = 8,
  parameter int Y_W = 8,
  localparam int P_W = X_W + Y_W
) (
  input  logic signed [X_W-1:0] a_i,
  input  logic signed [Y_W-1:0] b_i,
  output logic signed [P_W-1:0] prod_o
);
  logic signed [P_W-1:0] a_ext, b_ext;
  always_comb begin
    a_ext  = P_W'(a_i);
    b_ext  = P_W'(b_i);
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int P_W   = 16,
  parameter int ACC_W = 26
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [P_W-1:0]   prod_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] prod_ext;
  assign prod_ext = {{(ACC_W-P_W){prod_i[P_W-1]}}, prod_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= acc_o + prod_ext;
  end
endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  output logic             en_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             n_zero;

  assign n_zero  = (n_i == '0);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign en_o    = !done_o && !n_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (!done_o) begin
      if (n_zero) begin
        done_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_inc[CNT_W-1:0];
        done_o <= (cnt_inc == {1'b0, n_i});
      end
    end
  end
endmodule

// File: rtl/fxp_mac_count.sv
module fxp_mac_count
  import fxp_mac_pkg::*;
#(
  parameter int X_W   = 8,
  parameter int Y_W   = 8,
  parameter int CNT_W = 10,
  localparam int P_W   = X_W + Y_W,
  localparam int ACC_W = acc_width(X_W, Y_W, CNT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  input  logic [CNT_W-1:0] n_i,
  output logic [ACC_W-1:0] mac_o,
  output logic             ready_o
);
  logic signed [P_W-1:0]   prod;
  logic signed [ACC_W-1:0] acc;
  logic                    acc_en;

  fxp_mul #(.X_W(X_W), .Y_W(Y_W)) u_mul (
    .a_i   ($signed(x_i)),
    .b_i   ($signed(y_i)),
    .prod_o(prod)
  );

  run_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .n_i   (n_i),
    .en_o  (acc_en),
    .done_o(ready_o)
  );

  mac_accum #(.P_W(P_W), .ACC_W(ACC_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (acc_en),
    .prod_i(prod),
    .acc_o (acc)
  );

  assign mac_o = acc;
endmodule

// File: rtl/fxp_mac_count_chk.sv
module fxp_mac_count_chk #(
  parameter int X_W   = 8,
  parameter int Y_W   = 8,
  parameter int CNT_W = 10,
  parameter int ACC_W = 26
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [X_W-1:0]   x_i,
  input logic [Y_W-1:0]   y_i,
  input logic [CNT_W-1:0] n_i,
  input logic [ACC_W-1:0] mac_o,
  input logic             ready_o
);
  logic signed [ACC_W-1:0] ref_prod;
  logic [CNT_W:0]          edges_q;
  logic [CNT_W:0]          want_edges;

  assign ref_prod   = ACC_W'($signed(x_i)) * ACC_W'($signed(y_i));
  assign want_edges = (n_i == '0) ? (CNT_W+1)'(1) : {1'b0, n_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       edges_q <= '0;
    else if (!ready_o) edges_q <= edges_q + 1'b1;
  end

  // R1: outputs cleared while in reset
  always @(posedge clk_i)
    if (!rst_ni) p_reset_clear_r1: assert (mac_o == '0 && !ready_o);

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && n_i != '0) |=> (mac_o == $past(mac_o) + $past(ref_prod)));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && n_i != '0 && !mac_o[ACC_W-1] && !ref_prod[ACC_W-1])
      |=> !mac_o[ACC_W-1]);

  p_ready_at_n_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (edges_q == want_edges));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> (ready_o && $stable(mac_o)));

  p_zero_n_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && n_i == '0) |=> (ready_o && $stable(mac_o)));
endmodule

bind fxp_mac_count fxp_mac_count_chk #(
  .X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .x_i    (x_i),
  .y_i    (y_i),
  .n_i    (n_i),
  .mac_o  (mac_o),
  .ready_o(ready_o)
);

// File: tb/fxp_mac_count_bench.sv
`timescale 1ns/1ps
module fxp_mac_count_bench;
  localparam int X_W = 8, Y_W = 8, CNT_W = 10;
  localparam int ACC_W = X_W + Y_W + CNT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [X_W-1:0]   x = '0;
  logic [Y_W-1:0]   y = '0;
  logic [CNT_W-1:0] n = '0;
  logic [ACC_W-1:0] mac;
  logic             ready;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fxp_mac_count #(.X_W(X_W), .Y_W(Y_W), .CNT_W(CNT_W)) u_fxp_mac_count (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x), .y_i(y), .n_i(n),
    .mac_o(mac), .ready_o(ready)
  );

  function automatic longint smac();
    return longint'($signed(mac));
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [CNT_W-1:0] cnt);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 mac in reset", smac(), 0);
    check("R1 ready in reset", longint'(ready), 0);
    n = cnt;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode 0: random, 1: min*min, 2: min*max
  task automatic t_run(input int cnt, input int mode);
    longint ref_sum = 0;
    do_reset(CNT_W'(cnt));
    for (int i = 0; i < cnt; i++) begin
      check("R4 running sum", smac(), ref_sum);
      check("R5 ready low mid-run", longint'(ready), 0);
      case (mode)
        1: begin x = 8'h80; y = 8'h80; end
        2: begin x = 8'h80; y = 8'h7f; end
        default: begin x = X_W'($urandom); y = Y_W'($urandom); end
      endcase
      ref_sum += longint'($signed(x)) * longint'($signed(y));
      @(negedge clk);
    end
    if (mode != 0) check("R3 full-length extreme sum", smac(), ref_sum);
    else           check("R2 final sum", smac(), ref_sum);
    check("R5 ready after N-th", longint'(ready), 1);
    for (int k = 0; k < 4; k++) begin
      x = X_W'($urandom); y = Y_W'($urandom);
      @(negedge clk);
      check("R6 mac held", smac(), ref_sum);
      check("R6 ready held", longint'(ready), 1);
    end
  endtask

  task automatic t_zero();
    do_reset('0);
    x = 8'h7f; y = 8'h7f;
    check("R7 ready low before edge", longint'(ready), 0);
    @(negedge clk);
    check("R7 ready after first edge", longint'(ready), 1);
    check("R7 mac zero", smac(), 0);
    @(negedge clk);
    check("R7 mac still zero", smac(), 0);
  endtask

  task automatic t_async_reset();
    do_reset(10'd50);
    x = 8'h11; y = 8'h05;
    repeat (3) @(negedge clk);
    check("R4 partial sum", smac(), 3 * 17 * 5);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1 async mac clear", smac(), 0);
    check("R1 async ready clear", longint'(ready), 0);
  endtask

  initial begin
    t_async_reset();
    t_run(1, 0);
    t_run(5, 0);
    t_run(1000, 0);
    t_run(1023, 1);
    t_run(1023, 2);
    t_zero();
    t_run(2, 2);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule